// File: doc/BRIEF.md
# Byte-Wide Table Memory Access Unit

This unit moves single bytes between a 16-bit-wide program memory and an 8-bit data side. A one-byte transfer latch sits between the two. The CPU loads a 22-bit byte pointer and a target-select control register through a small register port. It then issues table-read or table-write strobes.

A table read fetches the addressed byte into the latch. The source is program memory, data EEPROM or configuration storage. A table write leaves every array untouched and places the latch byte into a 64-byte holding buffer. Later commit logic reads that buffer through a dedicated read port.

After each table operation the pointer can optionally step up or down. There is no alignment rule, so a run of byte transfers may start and stop at any address. A register with no storage behind it sits in the map for use by unlock sequences and always reads as zero.

Top module: `tblxfer_unit`

## Requirements
- R1: After reset the pointer, the latch, the control register and every holding byte are 0x00, and busy_o is low.
- R2: With program memory selected, a table read addresses word ptr[21:1]. It returns bits [7:0] of that word when ptr[0]=0 and bits [15:8] when ptr[0]=1, and any start address is allowed.
- R3: Control bit 6 set selects configuration storage whatever bit 7 holds. With bit 6 clear, bit 7 set selects program memory and bit 7 clear selects data EEPROM. The control register reads back only bits 7 and 6.
- R4: A table-read strobe accepted at one clock edge raises busy_o for exactly one cycle, and the latch holds the fetched byte after the following edge.
- R5: A table strobe that arrives while busy_o is high is ignored. It starts no memory read, writes no holding byte and does not move the pointer.
- R6: A table write stores the latch byte into holding byte ptr[5:0]. It changes no other holding byte and leaves the latch unchanged. It issues no program-memory read.
- R7: ptr_mode_i = 1 post-increments the pointer after an accepted table operation and ptr_mode_i = 2 post-decrements it, both modulo 2^22. Values 0 and 3 leave the pointer unchanged.
- R8: Register address 5 always reads 0x00, and writes to it alter no other register.
- R9: A program read at byte address >= 2*PM_WORDS, or a configuration read at address >= CFG_BYTES, returns 0xFF and asserts no memory read enable.
- R10: Data EEPROM reads use only ptr[log2(EE_BYTES)-1:0].
- R11: The register map is 0 = pointer bits [7:0], 1 = bits [15:8], 2 = bits [21:16], 3 = latch, 4 = control. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | CPU register select |
| reg_we_i | input | 1 | CPU register write strobe |
| reg_wdata_i | input | 8 | CPU register write data |
| reg_rdata_o | output | 8 | CPU register read data (combinational) |
| tbl_rd_i | input | 1 | Table-read strobe |
| tbl_wr_i | input | 1 | Table-write strobe (a read strobe wins if both are high) |
| ptr_mode_i | input | 2 | Pointer step after the operation: 0 none, 1 increment, 2 decrement |
| busy_o | output | 1 | Access in progress |
| pm_addr_o | output | 10 | Program memory word address |
| pm_re_o | output | 1 | Program memory read enable |
| pm_rdata_i | input | 16 | Program memory word, valid the cycle after pm_re_o |
| ee_addr_o | output | 8 | Data EEPROM byte address |
| ee_re_o | output | 1 | Data EEPROM read enable |
| ee_rdata_i | input | 8 | Data EEPROM byte, valid the cycle after ee_re_o |
| cfg_addr_o | output | 4 | Configuration byte address |
| cfg_re_o | output | 1 | Configuration read enable |
| cfg_rdata_i | input | 8 | Configuration byte, valid the cycle after cfg_re_o |
| hold_idx_i | input | 6 | Holding buffer read index |
| hold_rdata_o | output | 8 | Holding buffer byte at hold_idx_i |

## Verification
The checker watches four rules on every cycle:
- busy_o lasts only one cycle.
- No read enable fires while busy_o is high, and at most one read enable fires at a time.
- The pointer does not move without a strobe or a register write.
- The latch changes only on a read completion or a CPU write, and the dummy register reads zero.

Some properties are only shown by the bench scenarios: the byte chosen from each word, the target-select priority, the 0xFF answers outside the implemented ranges, wrap of the pointer in both directions, and which holding byte a write lands in while its neighbours stay untouched.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  typedef enum logic [1:0] {TGT_EE = 2'd0, TGT_PM = 2'd1, TGT_CFG = 2'd2} tgt_e;
  typedef enum logic [1:0] {STEP_NONE = 2'd0, STEP_INC = 2'd1, STEP_DEC = 2'd2} step_e;

  localparam logic [2:0] REG_PTR_L = 3'd0;
  localparam logic [2:0] REG_PTR_H = 3'd1;
  localparam logic [2:0] REG_PTR_U = 3'd2;
  localparam logic [2:0] REG_LATCH = 3'd3;
  localparam logic [2:0] REG_CTRL  = 3'd4;
  localparam logic [2:0] REG_UNLK  = 3'd5;

  localparam int CTRL_PROG_BIT = 7;
  localparam int CTRL_CFG_BIT  = 6;
endpackage

// File: rtl/tbl_ptr.sv
module tbl_ptr #(
  parameter int PW = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cpu_we_i,
  input  logic [7:0]    wdata_i,
  input  logic          step_i,
  input  logic [1:0]    mode_i,
  output logic [PW-1:0] ptr_o
);
  import tbl_pkg::*;
  localparam int UW = PW - 16;

  logic [PW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (|cpu_we_i) begin
      if (cpu_we_i[0]) ptr_d[7:0]     = wdata_i;
      if (cpu_we_i[1]) ptr_d[15:8]    = wdata_i;
      if (cpu_we_i[2]) ptr_d[PW-1:16] = wdata_i[UW-1:0];
    end else if (step_i) begin
      unique case (mode_i)
        STEP_INC: ptr_d = ptr_q + PW'(1);
        STEP_DEC: ptr_d = ptr_q - PW'(1);
        default:  ptr_d = ptr_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tbl_hold.sv
module tbl_hold #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [7:0]    wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))        mem_q[g] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/tbl_route.sv
module tbl_route #(
  parameter int PW        = 22,
  parameter int PM_WORDS  = 1024,
  parameter int EE_BYTES  = 256,
  parameter int CFG_BYTES = 16,
  localparam int PM_AW  = $clog2(PM_WORDS),
  localparam int EE_AW  = $clog2(EE_BYTES),
  localparam int CFG_AW = $clog2(CFG_BYTES)
) (
  input  logic              go_i,
  input  logic [PW-1:0]     ptr_i,
  input  logic              prog_sel_i,
  input  logic              cfg_sel_i,
  output tbl_pkg::tgt_e     tgt_o,
  output logic              oor_o,
  output logic [PM_AW-1:0]  pm_addr_o,
  output logic              pm_re_o,
  output logic [EE_AW-1:0]  ee_addr_o,
  output logic              ee_re_o,
  output logic [CFG_AW-1:0] cfg_addr_o,
  output logic              cfg_re_o
);
  import tbl_pkg::*;
  localparam logic [PW-1:0] PM_LIMIT  = PW'(2 * PM_WORDS);
  localparam logic [PW-1:0] CFG_LIMIT = PW'(CFG_BYTES);

  always_comb begin
    // configuration select overrides the program/EEPROM choice
    if (cfg_sel_i)       tgt_o = TGT_CFG;
    else if (prog_sel_i) tgt_o = TGT_PM;
    else                 tgt_o = TGT_EE;
    unique case (tgt_o)
      TGT_PM:  oor_o = ptr_i >= PM_LIMIT;
      TGT_CFG: oor_o = ptr_i >= CFG_LIMIT;
      default: oor_o = 1'b0;
    endcase
  end

  assign pm_addr_o  = ptr_i[PM_AW:1];
  assign ee_addr_o  = ptr_i[EE_AW-1:0];
  assign cfg_addr_o = ptr_i[CFG_AW-1:0];
  assign pm_re_o    = go_i && tgt_o == TGT_PM  && !oor_o;
  assign ee_re_o    = go_i && tgt_o == TGT_EE;
  assign cfg_re_o   = go_i && tgt_o == TGT_CFG && !oor_o;
endmodule

// File: rtl/tblxfer_unit.sv
module tblxfer_unit #(
  parameter int PW         = 22,
  parameter int PM_WORDS   = 1024,
  parameter int EE_BYTES   = 256,
  parameter int CFG_BYTES  = 16,
  parameter int HOLD_BYTES = 64,
  localparam int PM_AW  = $clog2(PM_WORDS),
  localparam int EE_AW  = $clog2(EE_BYTES),
  localparam int CFG_AW = $clog2(CFG_BYTES),
  localparam int HW     = $clog2(HOLD_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              tbl_rd_i,
  input  logic              tbl_wr_i,
  input  logic [1:0]        ptr_mode_i,
  output logic              busy_o,
  output logic [PM_AW-1:0]  pm_addr_o,
  output logic              pm_re_o,
  input  logic [15:0]       pm_rdata_i,
  output logic [EE_AW-1:0]  ee_addr_o,
  output logic              ee_re_o,
  input  logic [7:0]        ee_rdata_i,
  output logic [CFG_AW-1:0] cfg_addr_o,
  output logic              cfg_re_o,
  input  logic [7:0]        cfg_rdata_i,
  input  logic [HW-1:0]     hold_idx_i,
  output logic [7:0]        hold_rdata_o
);
  import tbl_pkg::*;

  logic          busy_q, rd_pend_q, bsel_q, oor_q;
  tgt_e          tgt_q, tgt_w;
  logic          oor_w;
  logic [7:0]    latch_q, fetch_byte;
  logic [1:0]    ctrl_q;
  logic [PW-1:0] ptr_q;
  logic          go_rd, go_wr;
  logic [2:0]    ptr_we;

  assign go_rd  = tbl_rd_i && !busy_q;
  assign go_wr  = tbl_wr_i && !tbl_rd_i && !busy_q;
  assign ptr_we = {reg_we_i && reg_addr_i == REG_PTR_U,
                   reg_we_i && reg_addr_i == REG_PTR_H,
                   reg_we_i && reg_addr_i == REG_PTR_L};

  tbl_ptr #(.PW(PW)) u_ptr (
    .clk_i, .rst_ni,
    .cpu_we_i (ptr_we),
    .wdata_i  (reg_wdata_i),
    .step_i   (go_rd || go_wr),
    .mode_i   (ptr_mode_i),
    .ptr_o    (ptr_q)
  );

  tbl_route #(.PW(PW), .PM_WORDS(PM_WORDS), .EE_BYTES(EE_BYTES), .CFG_BYTES(CFG_BYTES)) u_route (
    .go_i       (go_rd),
    .ptr_i      (ptr_q),
    .prog_sel_i (ctrl_q[1]),
    .cfg_sel_i  (ctrl_q[0]),
    .tgt_o      (tgt_w),
    .oor_o      (oor_w),
    .pm_addr_o, .pm_re_o,
    .ee_addr_o, .ee_re_o,
    .cfg_addr_o, .cfg_re_o
  );

  tbl_hold #(.DEPTH(HOLD_BYTES)) u_hold (
    .clk_i, .rst_ni,
    .we_i    (go_wr),
    .widx_i  (ptr_q[HW-1:0]),
    .wdata_i (latch_q),
    .ridx_i  (hold_idx_i),
    .rdata_o (hold_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      bsel_q    <= 1'b0;
      oor_q     <= 1'b0;
      tgt_q     <= TGT_EE;
    end else begin
      busy_q    <= go_rd || go_wr;
      rd_pend_q <= go_rd;
      if (go_rd) begin
        bsel_q <= ptr_q[0];
        oor_q  <= oor_w;
        tgt_q  <= tgt_w;
      end
    end

  always_comb begin
    unique case (tgt_q)
      TGT_PM:  fetch_byte = oor_q ? 8'hFF : (bsel_q ? pm_rdata_i[15:8] : pm_rdata_i[7:0]);
      TGT_CFG: fetch_byte = oor_q ? 8'hFF : cfg_rdata_i;
      default: fetch_byte = ee_rdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                     latch_q <= '0;
    else if (rd_pend_q)                              latch_q <= fetch_byte;
    else if (reg_we_i && reg_addr_i == REG_LATCH)    latch_q <= reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                     ctrl_q <= '0;
    else if (reg_we_i && reg_addr_i == REG_CTRL)
      ctrl_q <= {reg_wdata_i[CTRL_PROG_BIT], reg_wdata_i[CTRL_CFG_BIT]};

  always_comb begin
    reg_rdata_o = 8'h00;
    unique case (reg_addr_i)
      REG_PTR_L: reg_rdata_o = ptr_q[7:0];
      REG_PTR_H: reg_rdata_o = ptr_q[15:8];
      REG_PTR_U: reg_rdata_o = 8'(ptr_q[PW-1:16]);
      REG_LATCH: reg_rdata_o = latch_q;
      REG_CTRL:  reg_rdata_o = {ctrl_q, 6'b0};
      default:   reg_rdata_o = 8'h00;  // unlock register and unmapped space
    endcase
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/tbl_chk.sv
module tbl_chk #(
  parameter int PW = 22
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tbl_rd_i,
  input logic          tbl_wr_i,
  input logic          reg_we_i,
  input logic [2:0]    reg_addr_i,
  input logic [7:0]    reg_rdata_o,
  input logic          busy_o,
  input logic          pm_re_o,
  input logic          ee_re_o,
  input logic          cfg_re_o,
  input logic [7:0]    latch_q,
  input logic [PW-1:0] ptr_q
);
  // R4
  a_r4_busy_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  // R4
  a_r4_latch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(reg_we_i && reg_addr_i == 3'd3)) |=> $stable(latch_q));

  // R5
  a_r5_no_read_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(pm_re_o || ee_re_o || cfg_re_o));

  // R3
  a_r3_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pm_re_o, ee_re_o, cfg_re_o}));

  // R7
  a_r7_ptr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tbl_rd_i && !tbl_wr_i && !(reg_we_i && reg_addr_i <= 3'd2)) |=> $stable(ptr_q));

  // R8
  a_r8_unlock_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 3'd5) |-> reg_rdata_o == 8'h00);
endmodule

bind tblxfer_unit tbl_chk #(.PW(PW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tbl_rd_i    (tbl_rd_i),
  .tbl_wr_i    (tbl_wr_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .busy_o      (busy_o),
  .pm_re_o     (pm_re_o),
  .ee_re_o     (ee_re_o),
  .cfg_re_o    (cfg_re_o),
  .latch_q     (latch_q),
  .ptr_q       (ptr_q)
);

// File: tb/sim_tblxfer_unit.sv
`timescale 1ns/1ps
module sim_tblxfer_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  reg_addr_i = 3'd3;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        tbl_rd_i = 1'b0, tbl_wr_i = 1'b0;
  logic [1:0]  ptr_mode_i = 2'd0;
  logic        busy_o;
  logic [9:0]  pm_addr_o;
  logic        pm_re_o;
  logic [15:0] pm_rdata_i;
  logic [7:0]  ee_addr_o;
  logic        ee_re_o;
  logic [7:0]  ee_rdata_i;
  logic [3:0]  cfg_addr_o;
  logic        cfg_re_o;
  logic [7:0]  cfg_rdata_i;
  logic [5:0]  hold_idx_i = '0;
  logic [7:0]  hold_rdata_o;

  int checks = 0, errors = 0, pm_cnt = 0;
  bit busy_prev = 0;
  logic [8:0] exp_q[$];
  int         tag_q[$];

  always #2 clk_i = ~clk_i;

  tblxfer_unit u0 (.*);

  function automatic logic [15:0] pm_word(input logic [9:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
  endfunction
  function automatic logic [7:0] ee_byte(input logic [7:0] a);
    return a ^ 8'h33;
  endfunction
  function automatic logic [7:0] cfg_byte(input logic [3:0] a);
    return {a, 4'h9};
  endfunction

  always_ff @(posedge clk_i) begin
    if (pm_re_o)  pm_rdata_i  <= pm_word(pm_addr_o);
    if (ee_re_o)  ee_rdata_i  <= ee_byte(ee_addr_o);
    if (cfg_re_o) cfg_rdata_i <= cfg_byte(cfg_addr_o);
  end

  always @(posedge clk_i) if (pm_re_o) pm_cnt++;

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: pop one expected item per completed access
  always @(negedge clk_i) begin
    if (busy_prev && !busy_o && exp_q.size() > 0) begin
      automatic logic [8:0] e = exp_q.pop_front();
      automatic int t = tag_q.pop_front();
      check(t, e[8] ? reg_rdata_o : hold_rdata_o, e[7:0]);
    end
    busy_prev = busy_o;
  end

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = 3'd3;
  endtask

  task automatic reg_chk(input int req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 check(req, reg_rdata_o, exp);
    reg_addr_i = 3'd3;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    reg_wr(3'd0, p[7:0]);
    reg_wr(3'd1, p[15:8]);
    reg_wr(3'd2, {2'b0, p[21:16]});
  endtask

  task automatic ptr_chk(input int req, input logic [21:0] p);
    reg_chk(req, 3'd0, p[7:0]);
    reg_chk(req, 3'd1, p[15:8]);
    reg_chk(req, 3'd2, {2'b0, p[21:16]});
  endtask

  // hold_strobe keeps the strobe high into the busy cycle
  task automatic tbl_op(input bit rd, input logic [1:0] mode, input logic [7:0] exp,
                        input int req, input bit hold_strobe);
    exp_q.push_back({rd, exp});
    tag_q.push_back(req);
    @(negedge clk_i);
    tbl_rd_i = rd; tbl_wr_i = !rd; ptr_mode_i = mode;
    @(negedge clk_i);
    if (!hold_strobe) begin tbl_rd_i = 0; tbl_wr_i = 0; end
    @(negedge clk_i);
    tbl_rd_i = 0; tbl_wr_i = 0; ptr_mode_i = 2'd0;
    @(negedge clk_i);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    ptr_chk(1, 22'h0);
    reg_chk(1, 3'd3, 8'h00);
    reg_chk(1, 3'd4, 8'h00);
    checks++; if (busy_o !== 1'b0) begin errors++; $display("FAIL R1 actual %0b expected 0", busy_o); end
    for (int i = 0; i < 64; i += 21) begin
      hold_idx_i = 6'(i); #1 check(1, hold_rdata_o, 8'h00);
    end
    reg_chk(11, 3'd7, 8'h00);  // R11 unmapped

    // R2 program reads, low then high byte, R7 increment
    reg_wr(3'd4, 8'h80);
    reg_chk(3, 3'd4, 8'h80);
    set_ptr(22'h10);
    tbl_op(1, 2'd1, pm_word(10'h8)[7:0], 2, 0);
    tbl_op(1, 2'd1, pm_word(10'h8)[15:8], 2, 0);
    ptr_chk(7, 22'h12);
    // R2 odd start address
    set_ptr(22'h21);
    tbl_op(1, 2'd1, pm_word(10'h10)[15:8], 2, 0);
    tbl_op(1, 2'd0, pm_word(10'h11)[7:0], 2, 0);
    ptr_chk(7, 22'h22);

    // R9 program out of range
    c0 = pm_cnt;
    set_ptr(22'h800);
    tbl_op(1, 2'd0, 8'hFF, 9, 0);
    check(9, 8'(pm_cnt - c0), 8'd0);

    // R7 decrement wraps, then increment wraps
    set_ptr(22'h0);
    tbl_op(1, 2'd2, pm_word(10'h0)[7:0], 7, 0);
    ptr_chk(7, 22'h3FFFFF);
    tbl_op(1, 2'd1, 8'hFF, 9, 0);
    ptr_chk(7, 22'h0);

    // R10 EEPROM folds address, R3 select
    reg_wr(3'd4, 8'h00);
    set_ptr(22'h105);
    tbl_op(1, 2'd0, ee_byte(8'h05), 10, 0);

    // R3 configuration override
    reg_wr(3'd4, 8'h40);
    set_ptr(22'h3);
    tbl_op(1, 2'd0, cfg_byte(4'h3), 3, 0);
    reg_wr(3'd4, 8'hFF);
    reg_chk(3, 3'd4, 8'hC0);
    tbl_op(1, 2'd0, cfg_byte(4'h3), 3, 0);
    set_ptr(22'h20);
    tbl_op(1, 2'd0, 8'hFF, 9, 0);

    // R5 strobe during busy is ignored
    reg_wr(3'd4, 8'h80);
    set_ptr(22'h30);
    c0 = pm_cnt;
    tbl_op(1, 2'd1, pm_word(10'h18)[7:0], 5, 1);
    check(5, 8'(pm_cnt - c0), 8'd1);
    ptr_chk(5, 22'h31);

    // R6 table write into holding buffer
    reg_wr(3'd3, 8'hAB);
    set_ptr(22'h45);
    c0 = pm_cnt;
    hold_idx_i = 6'd5;
    tbl_op(0, 2'd0, 8'hAB, 6, 0);
    check(6, 8'(pm_cnt - c0), 8'd0);
    hold_idx_i = 6'd4; #1 check(6, hold_rdata_o, 8'h00);
    hold_idx_i = 6'd6; #1 check(6, hold_rdata_o, 8'h00);
    reg_chk(6, 3'd3, 8'hAB);
    ptr_chk(7, 22'h45);
    reg_wr(3'd3, 8'h5C);
    set_ptr(22'h7F);
    hold_idx_i = 6'd63;
    tbl_op(0, 2'd1, 8'h5C, 6, 0);
    ptr_chk(7, 22'h80);
    hold_idx_i = 6'd5; #1 check(6, hold_rdata_o, 8'hAB);

    // R8 unlock register
    reg_wr(3'd5, 8'h55);
    reg_chk(8, 3'd5, 8'h00);
    reg_chk(8, 3'd3, 8'h5C);
    reg_chk(8, 3'd4, 8'h80);
    ptr_chk(8, 22'h80);

    repeat (4) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin errors++; $display("FAIL R4 actual %0d expected 0 pending", exp_q.size()); end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule